// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Peripheral Override

This block is the controller for one six-pin I/O port on a microcontroller-style register bus. Software owns a direction register and an output latch, both written and read back through a small register interface. The latch value goes to a pin's pad driver only while the direction bit for that pin is 0. The port address returns the pad levels after they pass through a synchronizer. A write to the port address lands in the latch.

Peripherals can take a pin over without touching the software registers. Each of pins 0 to 4 has a primary peripheral output, a secondary (enhanced-PWM) output that a shutdown event can force to high impedance, and a request that forces the pin to be an input. A fixed priority decides between them. Pin 5 has no output driver. A static configuration bit decides whether pin 5 is a plain digital input or an active-low master-clear request. In master-clear mode the port and latch bits for pin 5 read as 0.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0x1F, the output latch reads 0x00, and every pad output enable is 0.
- R2: When no peripheral claims pin i (0 to 4), pad_oe[i] is the inverse of direction bit i. While pad_oe[i] is 1, pad_out[i] equals latch bit i. pad_out is not defined while pad_oe is 0.
- R3: A write to address 1 (latch) or address 0 (port) stores wdata[5:0] into the latch. Reading address 1 returns the stored latch and not the pad level. Bits 7:6 read as 0.
- R4: Reading address 0 returns the pad levels as they were sampled through a two-flop synchronizer, so a pad change shows on the second rising edge. Bits 7:6 read as 0.
- R5: A write to address 2 stores wdata[4:0] into the direction register. Reading address 2 returns exactly that value in bits 4:0 and 0 in bits 7:5, whatever the peripheral overrides are doing.
- R6: When pri_oe[i] is 1, pad_oe[i] is 1 and pad_out[i] equals pri_out[i]. This holds regardless of the secondary request, the shutdown input, the force-input request, the direction bit and the latch.
- R7: When pri_oe[i] is 0, sec_oe[i] is 1 and sec_shdn[i] is 0, pad_oe[i] is 1 and pad_out[i] equals sec_out[i].
- R8: When pri_oe[i] is 0, sec_oe[i] is 1 and sec_shdn[i] is 1, pad_oe[i] is 0.
- R9: When neither output request is active and force_in[i] is 1, pad_oe[i] is 0, even if direction bit i is 0.
- R10: With cfg_mclr_en = 0, port bit 5 reads the synchronized pad 5 level, latch bit 5 reads its stored value, and mclr_req is 0.
- R11: With cfg_mclr_en = 1, port bit 5 and latch bit 5 read as 0, and mclr_req is 1 exactly while the synchronized pad 5 level is 0.
- R12: Address 3 reads as 0x00. A write to address 3 changes neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_mclr_en | input | 1 | Static configuration: 1 selects master-clear use of pin 5 |
| bus_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 unused |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, available in the same cycle |
| pad_in | input | 6 | Pad input levels, asynchronous |
| pad_oe | output | 5 | Output enable per bidirectional pad |
| pad_out | output | 5 | Output data per bidirectional pad |
| pri_oe | input | 5 | Primary peripheral output request per pin |
| pri_out | input | 5 | Primary peripheral output data |
| sec_oe | input | 5 | Secondary (enhanced-PWM) output request per pin |
| sec_out | input | 5 | Secondary output data |
| sec_shdn | input | 5 | Shutdown tristate for the secondary output |
| force_in | input | 5 | Peripheral request that forces the pin to be an input |
| mclr_req | output | 1 | Master-clear request, active high |

## Verification
Directed cases cover each owner of a pin on its own: software direction alone, primary over secondary, a secondary in shutdown, and a forced input with direction 0. Together they show that the priority chain is ordered as required and does not merely OR the requests together. Pad levels are chosen to differ from the latch, so a latch readback that returned the pin level would be caught. The direction register is read back while every override is active. Both settings of the configuration bit are tried with pad 5 high and low to separate the plain-input and master-clear views of pin 5. Random stimulus with sparse primary requests then mixes register writes, pad changes and overlapping override requests. A reference model in the bench predicts every output.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int GP_ADDR_W = 2;

  typedef enum logic [GP_ADDR_W-1:0] {
    GP_ADDR_PORT = 2'd0,
    GP_ADDR_LAT  = 2'd1,
    GP_ADDR_DIR  = 2'd2,
    GP_ADDR_NONE = 2'd3
  } gp_addr_e;

  typedef enum logic [1:0] {
    OWN_PRI,
    OWN_SEC,
    OWN_FORCE_IN,
    OWN_SW
  } pin_owner_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [GP_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_PINS-1:0]  lat_q,
  output logic [NUM_PINS-2:0]  dir_q
);
  localparam int NBIDIR = NUM_PINS - 1;

  logic                lat_en;
  logic                dir_en;
  logic [NUM_PINS-1:0] lat_d;
  logic [NBIDIR-1:0]   dir_d;

  always_comb begin
    lat_en = wr && ((addr == GP_ADDR_PORT) || (addr == GP_ADDR_LAT));
    dir_en = wr && (addr == GP_ADDR_DIR);
    lat_d  = lat_en ? wdata[NUM_PINS-1:0] : lat_q;
    dir_d  = dir_en ? wdata[NBIDIR-1:0]   : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      lat_q <= lat_d;
      dir_q <= dir_d;
    end
  end

  // A direction write lands one cycle later (R5)
  assert_dir_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == GP_ADDR_DIR) |=> (dir_q == $past(wdata[NBIDIR-1:0])));

  // A latch write through either address lands one cycle later (R3)
  assert_lat_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == GP_ADDR_PORT || addr == GP_ADDR_LAT))
      |=> (lat_q == $past(wdata[NUM_PINS-1:0])));

  // A write to the unused address leaves both registers untouched (R12)
  assert_unused_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == GP_ADDR_NONE) |=> ($stable(lat_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic dir_bit,
  input  logic lat_bit,
  input  logic pri_oe,
  input  logic pri_out,
  input  logic sec_oe,
  input  logic sec_out,
  input  logic sec_shdn,
  input  logic force_in,
  output logic pad_oe,
  output logic pad_out
);
  pin_owner_e owner;

  always_comb begin
    if (pri_oe)        owner = OWN_PRI;
    else if (sec_oe)   owner = OWN_SEC;
    else if (force_in) owner = OWN_FORCE_IN;
    else               owner = OWN_SW;
  end

  always_comb begin
    unique case (owner)
      OWN_PRI: begin
        pad_oe  = 1'b1;
        pad_out = pri_out;
      end
      OWN_SEC: begin
        pad_oe  = ~sec_shdn;
        pad_out = sec_out;
      end
      OWN_FORCE_IN: begin
        pad_oe  = 1'b0;
        pad_out = lat_bit;
      end
      default: begin
        pad_oe  = ~dir_bit;
        pad_out = lat_bit;
      end
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_mclr_en,
  input  logic [GP_ADDR_W-1:0] bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0]  pad_in,
  output logic [NUM_PINS-2:0]  pad_oe,
  output logic [NUM_PINS-2:0]  pad_out,
  input  logic [NUM_PINS-2:0]  pri_oe,
  input  logic [NUM_PINS-2:0]  pri_out,
  input  logic [NUM_PINS-2:0]  sec_oe,
  input  logic [NUM_PINS-2:0]  sec_out,
  input  logic [NUM_PINS-2:0]  sec_shdn,
  input  logic [NUM_PINS-2:0]  force_in,
  output logic                 mclr_req
);
  localparam int NBIDIR = NUM_PINS - 1;
  localparam int IN_PIN = NUM_PINS - 1;

  logic [NUM_PINS-1:0] pad_sync;
  logic [NUM_PINS-1:0] lat_q;
  logic [NBIDIR-1:0]   dir_q;
  logic [NUM_PINS-1:0] port_view;
  logic [NUM_PINS-1:0] lat_view;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_in),
    .dout (pad_sync)
  );

  gpio_regfile #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (bus_wr),
    .addr (bus_addr),
    .wdata(bus_wdata),
    .lat_q(lat_q),
    .dir_q(dir_q)
  );

  for (genvar p = 0; p < NBIDIR; p++) begin : g_pin
    gpio_pin_mux u_mux (
      .dir_bit (dir_q[p]),
      .lat_bit (lat_q[p]),
      .pri_oe  (pri_oe[p]),
      .pri_out (pri_out[p]),
      .sec_oe  (sec_oe[p]),
      .sec_out (sec_out[p]),
      .sec_shdn(sec_shdn[p]),
      .force_in(force_in[p]),
      .pad_oe  (pad_oe[p]),
      .pad_out (pad_out[p])
    );

    // Primary request owns the pad (R6)
    assert_pri_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pri_oe[p] |-> (pad_oe[p] && pad_out[p] == pri_out[p]));

    // Secondary in shutdown releases the pad (R8)
    assert_shdn_tri_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pri_oe[p] && sec_oe[p] && sec_shdn[p]) |-> !pad_oe[p]);

    // Forced input disables the driver (R9)
    assert_force_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pri_oe[p] && !sec_oe[p] && force_in[p]) |-> !pad_oe[p]);
  end

  always_comb begin
    port_view         = pad_sync;
    port_view[IN_PIN] = pad_sync[IN_PIN] & ~cfg_mclr_en;
    lat_view          = lat_q;
    lat_view[IN_PIN]  = lat_q[IN_PIN] & ~cfg_mclr_en;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      GP_ADDR_PORT: bus_rdata[NUM_PINS-1:0] = port_view;
      GP_ADDR_LAT:  bus_rdata[NUM_PINS-1:0] = lat_view;
      GP_ADDR_DIR:  bus_rdata[NBIDIR-1:0]   = dir_q;
      default:      bus_rdata = '0;
    endcase
  end

  assign mclr_req = cfg_mclr_en & ~pad_sync[IN_PIN];

  // Master clear only ever requested in that configuration (R11)
  assert_mclr_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_req |-> cfg_mclr_en);

  // Unimplemented direction bits read as zero (R5)
  assert_dir_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == GP_ADDR_DIR) |-> (bus_rdata[DATA_W-1:NBIDIR] == '0));

  // Pin-5 latch bit hidden in master-clear mode (R11)
  assert_lat5_hidden_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mclr_en && bus_addr == GP_ADDR_LAT) |-> !bus_rdata[IN_PIN]);
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic       clk;
  logic       rst_n;
  logic       cfg_mclr_en;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [5:0] pad_in;
  logic [4:0] pad_oe, pad_out;
  logic [4:0] pri_oe, pri_out, sec_oe, sec_out, sec_shdn, force_in;
  logic       mclr_req;

  int checks = 0;
  int errors = 0;

  logic [5:0] m_lat;
  logic [4:0] m_dir;
  logic [5:0] m_s1, m_s2;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_mclr_en(cfg_mclr_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pri_oe(pri_oe), .pri_out(pri_out),
    .sec_oe(sec_oe), .sec_out(sec_out), .sec_shdn(sec_shdn),
    .force_in(force_in), .mclr_req(mclr_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    logic [7:0] r;
    r = 8'h00;
    case (a)
      2'd0: r = {2'b00, m_s2[5] & ~cfg_mclr_en, m_s2[4:0]};
      2'd1: r = {2'b00, m_lat[5] & ~cfg_mclr_en, m_lat[4:0]};
      2'd2: r = {3'b000, m_dir};
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic string rd_tag(input logic [1:0] a);
    case (a)
      2'd0: return "R4";
      2'd1: return "R3";
      2'd2: return "R5";
      default: return "R12";
    endcase
  endfunction

  task automatic step();
    #1;
    for (int i = 0; i < 5; i++) begin
      logic eo, ed;
      string t;
      if (pri_oe[i]) begin
        eo = 1'b1; ed = pri_out[i]; t = "R6";
      end else if (sec_oe[i]) begin
        eo = ~sec_shdn[i]; ed = sec_out[i]; t = sec_shdn[i] ? "R8" : "R7";
      end else if (force_in[i]) begin
        eo = 1'b0; ed = 1'b0; t = "R9";
      end else begin
        eo = ~m_dir[i]; ed = m_lat[i]; t = "R2";
      end
      check({t, " pad_oe"}, {7'd0, pad_oe[i]}, {7'd0, eo});
      if (eo) check({t, " pad_out"}, {7'd0, pad_out[i]}, {7'd0, ed});
    end
    check({rd_tag(bus_addr), " rdata"}, bus_rdata, exp_rdata(bus_addr));
    check(cfg_mclr_en ? "R11 mclr" : "R10 mclr", {7'd0, mclr_req},
          {7'd0, cfg_mclr_en & ~m_s2[5]});
    if (bus_wr) begin
      if (bus_addr == 2'd0 || bus_addr == 2'd1) m_lat = bus_wdata[5:0];
      else if (bus_addr == 2'd2) m_dir = bus_wdata[4:0];
    end
    m_s2 = m_s1;
    m_s1 = pad_in;
    @(negedge clk);
  endtask

  task automatic clear_periph();
    pri_oe = 0; pri_out = 0; sec_oe = 0; sec_out = 0; sec_shdn = 0; force_in = 0;
  endtask

  task automatic bus(input logic [1:0] a, input logic w, input logic [7:0] d);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; cfg_mclr_en = 1'b0; bus_addr = 0; bus_wr = 0; bus_wdata = 0;
    pad_in = 6'h00; clear_periph();
    m_lat = 6'h00; m_dir = 5'h1F; m_s1 = 6'h00; m_s2 = 6'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    bus_addr = 2'd2; #1 check("R1 dir reset", bus_rdata, 8'h1F);
    bus_addr = 2'd1; #1 check("R1 lat reset", bus_rdata, 8'h00);
    check("R1 oe reset", {3'b0, pad_oe}, 8'h00);
    @(negedge clk);

    // R2, R3: software-driven pins, latch readback differs from pads
    pad_in = 6'h2A;
    bus(2'd1, 1'b1, 8'hD5);
    bus(2'd2, 1'b1, 8'hE0);
    bus(2'd1, 1'b0, 8'h00);
    bus(2'd0, 1'b1, 8'h0A);   // write via port address goes to latch
    bus(2'd1, 1'b0, 8'h00);
    bus(2'd0, 1'b0, 8'h00);   // R4 port readback

    // R6 priority over secondary and software; R5 readback unaffected
    pri_oe = 5'h1F; pri_out = 5'h05; sec_oe = 5'h1F; sec_out = 5'h1A;
    sec_shdn = 5'h1F; force_in = 5'h1F;
    bus(2'd2, 1'b0, 8'h00);
    // R7, R8
    pri_oe = 5'h00; sec_shdn = 5'h03;
    bus(2'd2, 1'b0, 8'h00);
    // R9 forced input with direction 0
    sec_oe = 5'h00;
    bus(2'd2, 1'b0, 8'h00);
    clear_periph();

    // R10: pin 5 as plain input
    cfg_mclr_en = 1'b0; pad_in = 6'h20;
    bus(2'd1, 1'b1, 8'h20);
    bus(2'd0, 1'b0, 8'h00);
    bus(2'd0, 1'b0, 8'h00);
    bus(2'd1, 1'b0, 8'h00);
    // R11: master-clear mode, pad 5 low then high
    cfg_mclr_en = 1'b1; pad_in = 6'h00;
    bus(2'd0, 1'b0, 8'h00);
    bus(2'd0, 1'b0, 8'h00);
    bus(2'd1, 1'b0, 8'h00);
    pad_in = 6'h3F;
    bus(2'd0, 1'b0, 8'h00);
    bus(2'd0, 1'b0, 8'h00);
    bus(2'd0, 1'b0, 8'h00);
    cfg_mclr_en = 1'b0;

    // R12: unused address
    bus(2'd3, 1'b1, 8'hFF);
    bus(2'd3, 1'b0, 8'h00);
    bus(2'd1, 1'b0, 8'h00);
    bus(2'd2, 1'b0, 8'h00);

    for (int n = 0; n < 400; n++) begin
      pad_in   = 6'($urandom);
      pri_oe   = 5'($urandom & $urandom & $urandom);
      pri_out  = 5'($urandom);
      sec_oe   = 5'($urandom & $urandom);
      sec_out  = 5'($urandom);
      sec_shdn = 5'($urandom);
      force_in = 5'($urandom);
      if (($urandom % 16) == 0) cfg_mclr_en = ~cfg_mclr_en;
      bus(2'($urandom), 1'($urandom), 8'($urandom));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule